// File: doc/BRIEF.md
# Two-lane shift-mask interpolator

This block is an arithmetic helper for software loops that walk tables or step through fixed-point coordinates. It holds two lanes, each with a 32-bit accumulator, a base register and a control word. Each lane takes an accumulator, shifts it right, keeps a chosen window of bits, can sign-extend that window, and adds its base. The two processed values and a third base are also summed into a combined result.

Software reaches the block through a simple register port. Writes load accumulators, bases and control words. Reads return either register contents or results. A peek read has no side effect. A pop read returns the same value and also loads the lane results back into the accumulators on that clock edge, so each pop advances the sequence by one step. The control word also selects cross-lane feeding, a raw-add bypass, constant upper pointer bits shown only on the bus, and a clamp mode on lane 0.

Top module: `shmask_interp`

## Requirements
- R1: After reset every accumulator, base and control register reads 0. Address map: 0 acc0, 1 acc1, 2 base0, 3 base1, 4 base2, 5 ctrl0, 6 ctrl1 (all written by wr_en and read back by rd_en). Results are read at 7 peek lane0, 8 peek lane1, 9 peek full, 10 pop lane0, 11 pop lane1 and 12 pop full. Any other address reads 0.
- R2: Control field [4:0] is a logical right-shift amount applied to the selected accumulator. The processed value keeps bits [9:5] (low) up to [14:10] (high) of the shifted value, both bounds inclusive, and zeroes all other bits. In normal mode lane result = base + processed value, modulo 2^32. Lane 0 uses base0 and lane 1 uses base1.
- R3: If the high bound is below the low bound, the processed value is 0.
- R4: With bit 15 set, the windowed value is sign-extended from the window's high bit before the base is added.
- R5: With bit 16 set, the lane reads the other lane's accumulator. This also applies when bit 18 is set.
- R6: With bit 18 set, the lane result is base + selected accumulator, with no shift or window. The full result is not affected.
- R7: Full result = base2 + lane0 processed value + lane1 processed value.
- R8: Control bits [20:19] are ORed into bits [29:28] of a lane result only on the read data. Pop writes back the unmodified value.
- R9: With bit 22 of ctrl0 set, the lane 0 result is its processed value clamped to the range [base0, base1]. The compare is signed if bit 15 is set. Bit 22 of ctrl1 has no effect.
- R10: A peek leaves the accumulators unchanged. A pop loads each accumulator with its own lane result, or with the other lane's result if bit 17 is set. A write in the same cycle takes priority over the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; a pop has its effect on the clock edge |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data |

## Verification
The hardest case to reach is a chain of pops with the cross-result select enabled. The accumulators that later reads depend on are then produced by the other lane's arithmetic, not loaded directly. The stimulus loads both lanes with small known values and pops once. It then reads both accumulators back to confirm that both hold lane 1's result. Signed clamping against a negative lower bound is reached by writing a negative base0 and a window whose high bit is set.

// File: rtl/shmask_interp.sv
module shmask_interp (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);
  localparam logic [3:0] A_ACC0 = 4'd0, A_ACC1 = 4'd1, A_BASE0 = 4'd2, A_BASE1 = 4'd3,
                         A_BASE2 = 4'd4, A_CTRL0 = 4'd5, A_CTRL1 = 4'd6,
                         A_PEEK0 = 4'd7, A_PEEK1 = 4'd8, A_PEEKF = 4'd9,
                         A_POP0 = 4'd10, A_POP1 = 4'd11, A_POPF = 4'd12;

  logic [31:0] acc0, acc1, base0, base1, base2, ctrl0, ctrl1;
  logic [31:0] src0, src1, proc0, proc1, res0, res1, full, clamped;
  logic        pop;

  function automatic logic [31:0] window(input logic [31:0] v, input logic [31:0] c);
    logic [31:0] sh, msk, m;
    logic [4:0]  lo, hi;
    lo  = c[9:5];
    hi  = c[14:10];
    sh  = v >> c[4:0];
    msk = (hi < lo) ? 32'd0 : ((32'hFFFF_FFFF << lo) & (32'hFFFF_FFFF >> (5'd31 - hi)));
    m   = sh & msk;
    if (c[15] && m[hi])
      m = m | (32'hFFFF_FFFF << hi);
    return m;
  endfunction

  assign src0  = ctrl0[16] ? acc1 : acc0;
  assign src1  = ctrl1[16] ? acc0 : acc1;
  assign proc0 = window(src0, ctrl0);
  assign proc1 = window(src1, ctrl1);

  always_comb begin
    if (ctrl0[15])
      clamped = ($signed(proc0) < $signed(base0)) ? base0 :
                ($signed(proc0) > $signed(base1)) ? base1 : proc0;
    else
      clamped = (proc0 < base0) ? base0 : (proc0 > base1) ? base1 : proc0;
  end

  assign res0 = ctrl0[22] ? clamped : (base0 + (ctrl0[18] ? src0 : proc0));
  assign res1 = base1 + (ctrl1[18] ? src1 : proc1);
  assign full = base2 + proc0 + proc1;
  assign pop  = rd_en && (addr == A_POP0 || addr == A_POP1 || addr == A_POPF);

  always_comb begin
    case (addr)
      A_ACC0:           rdata = acc0;
      A_ACC1:           rdata = acc1;
      A_BASE0:          rdata = base0;
      A_BASE1:          rdata = base1;
      A_BASE2:          rdata = base2;
      A_CTRL0:          rdata = ctrl0;
      A_CTRL1:          rdata = ctrl1;
      A_PEEK0, A_POP0:  rdata = res0 | {2'b00, ctrl0[20:19], 28'd0};
      A_PEEK1, A_POP1:  rdata = res1 | {2'b00, ctrl1[20:19], 28'd0};
      A_PEEKF, A_POPF:  rdata = full;
      default:          rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc0 <= '0; acc1 <= '0; base0 <= '0; base1 <= '0;
      base2 <= '0; ctrl0 <= '0; ctrl1 <= '0;
    end else begin
      if (pop) begin
        acc0 <= ctrl0[17] ? res1 : res0;
        acc1 <= ctrl1[17] ? res0 : res1;
      end
      if (wr_en) begin
        case (addr)
          A_ACC0:  acc0  <= wdata;
          A_ACC1:  acc1  <= wdata;
          A_BASE0: base0 <= wdata;
          A_BASE1: base1 <= wdata;
          A_BASE2: base2 <= wdata;
          A_CTRL0: ctrl0 <= wdata;
          A_CTRL1: ctrl1 <= wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

module shmask_interp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [3:0]  addr,
  input logic [31:0] rdata,
  input logic [31:0] acc0,
  input logic [31:0] acc1,
  input logic [31:0] base0,
  input logic [31:0] base1,
  input logic [31:0] ctrl0,
  input logic [31:0] ctrl1,
  input logic [31:0] res0,
  input logic [31:0] res1
);
  assert_peek_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr >= 4'd7 && addr <= 4'd9) |=> ($stable(acc0) && $stable(acc1)));

  assert_pop_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr >= 4'd10 && addr <= 4'd12) |=>
      (acc0 == $past(ctrl0[17] ? res1 : res0)) && (acc1 == $past(ctrl1[17] ? res0 : res1)));

  assert_force_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 4'd7) |-> ((rdata[29:28] & ctrl0[20:19]) == ctrl0[20:19]));

  assert_clamp_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl0[22] && !ctrl0[15] && base0 <= base1) |-> (res0 >= base0 && res0 <= base1));

  assert_empty_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl0[14:10] < ctrl0[9:5] && !ctrl0[18] && !ctrl0[22]) |-> (res0 == base0));
endmodule

bind shmask_interp shmask_interp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .acc0(acc0), .acc1(acc1), .base0(base0), .base1(base1), .ctrl0(ctrl0), .ctrl1(ctrl1),
  .res0(res0), .res1(res1)
);

// File: tb/shmask_interp_bench.sv
module shmask_interp_bench;
  logic        clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [3:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  shmask_interp u_shmask_interp (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                                 .addr(addr), .wdata(wdata), .rdata(rdata));

  always #10 clk = ~clk;

  function automatic logic [31:0] mkc(int sh, int lo, int hi, bit sg, bit xi, bit xr,
                                      bit raw, int frc, bit clp);
    logic [31:0] c = '0;
    c[4:0] = sh[4:0]; c[9:5] = lo[4:0]; c[14:10] = hi[4:0];
    c[15] = sg; c[16] = xi; c[17] = xr; c[18] = raw; c[20:19] = frc[1:0]; c[22] = clp;
    return c;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); rd_en = 1; addr = a;
    #1;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, rdata, exp);
    end
    @(negedge clk); rd_en = 0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 10; a++) rd_chk(a[3:0], 32'd0, "R1 reset");
    wr(4'd4, 32'hCAFE_0001);
    rd_chk(4'd4, 32'hCAFE_0001, "R1 readback");
    rd_chk(4'd15, 32'd0, "R1 unmapped");
    wr(4'd4, 32'd0);
  endtask

  task automatic t_window;
    wr(4'd0, 32'h1234_5678); wr(4'd2, 32'h100);
    wr(4'd5, mkc(4, 4, 11, 0, 0, 0, 0, 0, 0));
    rd_chk(4'd7, 32'h660, "R2 shift window");
    wr(4'd5, mkc(0, 8, 3, 0, 0, 0, 0, 0, 0));
    rd_chk(4'd7, 32'h100, "R3 inverted window");
  endtask

  task automatic t_signed;
    wr(4'd0, 32'hF0);
    wr(4'd5, mkc(4, 0, 3, 1, 0, 0, 0, 0, 0));
    rd_chk(4'd7, 32'hFF, "R4 signed");
    wr(4'd5, mkc(4, 0, 3, 0, 0, 0, 0, 0, 0));
    rd_chk(4'd7, 32'h10F, "R4 unsigned");
  endtask

  task automatic t_cross_raw;
    wr(4'd1, 32'hABCD_0001); wr(4'd4, 32'h1000); wr(4'd6, 32'd0);
    wr(4'd5, mkc(16, 0, 15, 0, 1, 0, 0, 0, 0));
    rd_chk(4'd7, 32'hACCD, "R5 cross input");
    rd_chk(4'd9, 32'hBBCE, "R7 full sum");
    wr(4'd5, mkc(16, 0, 15, 0, 1, 0, 1, 0, 0));
    rd_chk(4'd7, 32'hABCD_0101, "R5 R6 raw with cross");
    rd_chk(4'd9, 32'hBBCE, "R6 full unaffected");
  endtask

  task automatic t_force_pop;
    wr(4'd0, 32'd0); wr(4'd2, 32'h100);
    wr(4'd5, mkc(0, 0, 0, 0, 0, 0, 0, 3, 0));
    rd_chk(4'd7, 32'h3000_0100, "R8 forced bits peek");
    rd_chk(4'd0, 32'd0, "R10 peek leaves acc0");
    rd_chk(4'd10, 32'h3000_0100, "R8 pop read");
    rd_chk(4'd0, 32'h100, "R8 R10 pop writes unforced");
  endtask

  task automatic t_cross_result;
    wr(4'd0, 32'd5); wr(4'd1, 32'd7); wr(4'd2, 32'h10); wr(4'd3, 32'h20);
    wr(4'd5, mkc(0, 0, 7, 0, 0, 1, 0, 0, 0));
    wr(4'd6, mkc(0, 0, 7, 0, 0, 0, 0, 0, 0));
    rd_chk(4'd11, 32'h27, "R10 pop lane1");
    rd_chk(4'd0, 32'h27, "R10 cross result acc0");
    rd_chk(4'd1, 32'h27, "R10 own result acc1");
    @(negedge clk); rd_en = 1; wr_en = 1; addr = 4'd10; wdata = 32'h55;
    @(negedge clk); rd_en = 0; wr_en = 0;
    rd_chk(4'd1, 32'h47, "R10 pop with write acc1");
  endtask

  task automatic t_clamp;
    wr(4'd2, 32'h10); wr(4'd3, 32'h20);
    wr(4'd5, mkc(0, 0, 7, 0, 0, 0, 0, 0, 1));
    wr(4'd0, 32'h05); rd_chk(4'd7, 32'h10, "R9 clamp low");
    wr(4'd0, 32'h30); rd_chk(4'd7, 32'h20, "R9 clamp high");
    wr(4'd0, 32'h18); rd_chk(4'd7, 32'h18, "R9 in range");
    wr(4'd2, 32'hFFFF_FFF8);
    wr(4'd5, mkc(0, 0, 7, 1, 0, 0, 0, 0, 1));
    wr(4'd0, 32'hF0); rd_chk(4'd7, 32'hFFFF_FFF8, "R9 signed low");
    wr(4'd0, 32'h05); rd_chk(4'd7, 32'h05, "R9 signed in range");
    wr(4'd1, 32'h30); wr(4'd6, mkc(0, 0, 7, 0, 0, 0, 0, 0, 1));
    rd_chk(4'd8, 32'h50, "R9 lane1 ignores clamp");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_window; t_signed; t_cross_raw; t_force_pop; t_cross_result; t_clamp;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule